// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers eight interrupt request lines from peripherals and hands them to a processor one at a time. A rising edge on a request line sets a sticky pending bit. When at least one pending line is also enabled, a small state machine picks the lowest-numbered one and latches an 8-bit vector for it. The vector is a programmable 5-bit base in the upper bits followed by the 3-bit line number. The machine then raises a single interrupt output toward the processor.

The output stays high until the processor writes the acknowledge register. That write clears the pending bit of the line that was delivered and sends the machine back to watching the lines. A line whose enable bit is clear still records its edges. Its request is held and delivered once software sets the enable bit again.

The processor reaches the block through a plain register port: select, write strobe, 2-bit address and 8-bit data. Reads are combinational. The state machine has three named states:
- `ST_IDLE`: watching for enabled pending lines.
- `ST_LOAD`: building the vector.
- `ST_RAISE`: interrupt output high, waiting for acknowledge.

Its transitions are named as follows:
- `pick`: `ST_IDLE` to `ST_LOAD`, taken when any pending line is enabled; it latches the winning line number.
- `publish`: `ST_LOAD` to `ST_RAISE`, unconditional; it latches the vector.
- `ack`: `ST_RAISE` to `ST_IDLE`, taken on a write to the acknowledge address.
- `hold`: `ST_RAISE` to itself when no acknowledge arrives.
- `wait`: `ST_IDLE` to itself when nothing enabled is pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the interrupt output is low. A read of address 0 returns 0x20 (vector base for line 0 is 32), address 1 returns 0xFF (all lines enabled), and address 2 returns 0x00 (nothing pending).
- R2: A low-to-high change on request line n sets bit n of the pending register, which is read at address 2. A line held high after its request was acknowledged does not set the bit again.
- R3: The interrupt output goes high two clock edges after the edge that captured an enabled request while idle. It is low after the capture edge and after the next edge, and high after the second one.
- R4: While the interrupt output is high, a read of address 0 returns the programmed base in bits 7:3 and the delivered line number in bits 2:0. While the output is low, the same read returns the base with bits 2:0 zero.
- R5: A write to address 0 stores write-data bits 7:3 as the new base, and bits 2:0 of that write are ignored. Vectors delivered afterwards use the new base, so after reset line n maps to vector n + 32.
- R6: Once high, the interrupt output stays high until a write to address 3. It is low after the edge carrying that write, and the delivered line's pending bit is clear. A write to address 3 while the output is low changes neither the output nor the pending register.
- R7: A request on a line whose bit is clear in the enable register (address 1, bit n enables line n) stays pending and raises no interrupt. It is delivered after the bit is set.
- R8: When several enabled lines are pending, the lowest-numbered one is delivered first, and the rest follow in ascending order after each acknowledge.
- R9: While an interrupt waits for acknowledge, a new request, even on a lower-numbered line, does not change the vector read at address 0 and does not drop the output. That request is delivered after the acknowledge.
- R10: Address 2 is read-only, and a write to it leaves the pending register unchanged. A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 8 | Peripheral request lines, line n on bit n, synchronous to clk |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address: 0 base/vector, 1 enable, 2 pending, 3 acknowledge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational, zero when not reading |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
Suppose a latched line number is wrong, or the priority pick skips the lowest line. The very next read of address 0 while the output is high then shows a vector whose low bits differ from the bench's lowest enabled pending line. Suppose instead a pending bit is lost or cleared on the wrong line. Then the pending register read right after the acknowledge edge disagrees with the bench's model, and a masked request simply never fires once enabled. A state machine stuck in `ST_RAISE`, or leaving it early, shows up within one cycle as the output level after an acknowledge write, or as a drop while no acknowledge was written.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RAISE = 2'd2
    } ivc_state_e;

    localparam logic [1:0] ADDR_BASE = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_PEND = 2'd2;
    localparam logic [1:0] ADDR_ACK  = 2'd3;

endpackage

// File: rtl/ivc_edge_capture.sv
// Rising-edge detection per request line with sticky pending bits.
module ivc_edge_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= lines_i[g];
                // a fresh edge wins over a simultaneous clear
                pend_q[g] <= (pend_q[g] & ~clr_i[g]) | (lines_i[g] & ~prev_q[g]);
            end
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/ivc_prio_pick.sv
// Fixed priority: lowest index among the set request bits wins.
module ivc_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/ivc_regs.sv
// Software-visible configuration: vector base and per-line enables.
module ivc_regs
    import ivc_pkg::*;
#(
    parameter int N         = 8,
    parameter int VEC_W     = 8,
    parameter int IDX_W     = 3,
    parameter int RESET_VEC = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [1:0]             addr_i,
    input  logic [VEC_W-1:0]       wdata_i,
    output logic [VEC_W-IDX_W-1:0] base_o,
    output logic [N-1:0]           en_o
);

    localparam int BASE_W = VEC_W - IDX_W;
    localparam logic [BASE_W-1:0] RST_BASE = BASE_W'(RESET_VEC >> IDX_W);

    logic [BASE_W-1:0] base_q;
    logic [N-1:0]      en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RST_BASE;
            en_q   <= '1;
        end else if (wr_en_i) begin
            if (addr_i == ADDR_BASE) begin
                base_q <= wdata_i[VEC_W-1:IDX_W];
            end
            if (addr_i == ADDR_MASK) begin
                en_q <= N'(wdata_i);
            end
        end
    end

    assign base_o = base_q;
    assign en_o   = en_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int N         = 8,
    parameter int VEC_W     = 8,
    parameter int RESET_VEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_req_i,
    input  logic             bus_sel_i,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [VEC_W-1:0] bus_wdata_i,
    output logic [VEC_W-1:0] bus_rdata_o,
    output logic             cpu_irq_o
);

    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;
    localparam int BASE_W = VEC_W - IDX_W;

    ivc_state_e        state_q, state_d;
    logic [N-1:0]      pend_w;
    logic [N-1:0]      en_q;
    logic [N-1:0]      clr_w;
    logic [BASE_W-1:0] base_w;
    logic              any_w;
    logic [IDX_W-1:0]  win_w;
    logic [IDX_W-1:0]  line_q;
    logic [VEC_W-1:0]  vec_q;
    logic              wr_en_w;
    logic              ack_wr_w;

    assign wr_en_w  = bus_sel_i & bus_wr_i;
    assign ack_wr_w = wr_en_w & (bus_addr_i == ADDR_ACK);

    ivc_edge_capture #(.N(N)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_req_i),
        .clr_i   (clr_w),
        .pend_o  (pend_w)
    );

    ivc_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req_i (pend_w & en_q),
        .any_o (any_w),
        .idx_o (win_w)
    );

    ivc_regs #(.N(N), .VEC_W(VEC_W), .IDX_W(IDX_W), .RESET_VEC(RESET_VEC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_w),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .base_o  (base_w),
        .en_o    (en_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: wait, pick, publish, hold, ack
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_w)    state_d = ST_LOAD;
            ST_LOAD:                state_d = ST_RAISE;
            ST_RAISE: if (ack_wr_w) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // winner line and vector latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            vec_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && any_w) begin
                line_q <= win_w;
            end
            if (state_q == ST_LOAD) begin
                vec_q <= {base_w, line_q};
            end
        end
    end

    // outputs of the machine
    always_comb begin
        cpu_irq_o = 1'b0;
        clr_w     = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOAD:  ;
            ST_RAISE: begin
                cpu_irq_o = 1'b1;
                if (ack_wr_w) begin
                    clr_w[line_q] = 1'b1;
                end
            end
            default:  ;
        endcase
    end

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            unique case (bus_addr_i)
                ADDR_BASE: bus_rdata_o = (state_q == ST_RAISE) ? vec_q
                                                               : {base_w, {IDX_W{1'b0}}};
                ADDR_MASK: bus_rdata_o = VEC_W'(en_q);
                ADDR_PEND: bus_rdata_o = VEC_W'(pend_w);
                ADDR_ACK:  bus_rdata_o = '0;
                default:   bus_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel_i,
    input logic             bus_wr_i,
    input logic [1:0]       bus_addr_i,
    input logic [VEC_W-1:0] bus_rdata_o,
    input logic             cpu_irq_o,
    input logic [N-1:0]     pend,
    input logic [N-1:0]     en
);

    logic ack_wr;
    assign ack_wr = bus_sel_i && bus_wr_i && (bus_addr_i == 2'd3);

    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && !ack_wr) |=> cpu_irq_o);

    assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && ack_wr) |=> !cpu_irq_o);

    assert_pend_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> (($past(pend) & ~pend) == '0));

    assert_vec_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && bus_sel_i && !bus_wr_i && bus_addr_i == 2'd0)
            |-> pend[bus_rdata_o[IDX_W-1:0]]);

    assert_raise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq_o) |-> $past(|(pend & en), 2));

endmodule

bind irq_vector_ctrl ivc_checker #(.N(N), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .cpu_irq_o   (cpu_irq_o),
    .pend        (pend_w),
    .en          (en_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = 8'h00;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cpu_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [4:0] base_m;
    logic [7:0] en_m;
    logic [7:0] pend_m;

    always #10 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_irq_o(cpu_irq)
    );

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [4:0] b, input int line);
        return {b, 3'(line)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #2 d = rdata;
        sel = 1'b0;
    endtask

    // returns at the negedge right after the capture edge
    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        irq = irq | m;
        @(negedge clk);
        irq = irq & ~m;
    endtask

    task automatic wait_irq(input string req, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (cpu_irq) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        check(req, {31'd0, ok}, 32'd1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit ok;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, cpu_irq}, 32'd0);
        bus_read(2'd0, v); check("R1 base", v, 8'h20);
        bus_read(2'd1, v); check("R1 enable", v, 8'hFF);
        bus_read(2'd2, v); check("R1 pending", v, 8'h00);
        base_m = 5'd4; en_m = 8'hFF; pend_m = 8'h00;

        // R3 latency, R4/R5 default vector n+32
        pulse(8'h20);
        check("R3 after capture", {31'd0, cpu_irq}, 32'd0);
        @(negedge clk); check("R3 one edge", {31'd0, cpu_irq}, 32'd0);
        @(negedge clk); check("R3 two edges", {31'd0, cpu_irq}, 32'd1);
        bus_read(2'd0, v); check("R5 vector 32+5", v, 8'h25);
        bus_read(2'd2, v); check("R2 pending bit5", v, 8'h20);
        // R6 hold
        repeat (6) @(negedge clk);
        check("R6 hold", {31'd0, cpu_irq}, 32'd1);
        bus_read(2'd3, v); check("R10 ack reads 0", v, 8'h00);
        bus_write(2'd3, 8'h00);
        check("R6 dropped", {31'd0, cpu_irq}, 32'd0);
        bus_read(2'd2, v); check("R6 pending cleared", v, 8'h00);
        bus_read(2'd0, v); check("R4 idle read", v, 8'h20);

        // R5 reprogram base; low bits ignored
        bus_write(2'd0, 8'hA7); base_m = 5'h14;
        bus_read(2'd0, v); check("R5 base write", v, 8'hA0);
        pulse(8'h08); wait_irq("R5 irq", ok);
        bus_read(2'd0, v); check("R5 new vector", v, 8'hA3);
        bus_write(2'd3, 8'h00);

        // R7 masked line kept; R6 idle ack ignored; R10 pending write ignored
        bus_write(2'd1, 8'hBF);
        pulse(8'h40);
        repeat (8) @(negedge clk);
        check("R7 no irq while masked", {31'd0, cpu_irq}, 32'd0);
        bus_write(2'd3, 8'h00);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, v); check("R7 R10 kept pending", v, 8'h40);
        check("R6 idle ack no irq", {31'd0, cpu_irq}, 32'd0);
        bus_write(2'd1, 8'hFF);
        wait_irq("R7 fires on enable", ok);
        bus_read(2'd0, v); check("R7 vector", v, 8'hA6);
        bus_write(2'd3, 8'h00);

        // R8 priority
        bus_write(2'd1, 8'h00);
        pulse(8'h84);
        bus_write(2'd1, 8'hFF);
        wait_irq("R8 first", ok);
        bus_read(2'd0, v); check("R8 lowest first", v, 8'hA2);
        bus_write(2'd3, 8'h00);
        wait_irq("R8 second", ok);
        bus_read(2'd0, v); check("R8 then next", v, 8'hA7);
        bus_write(2'd3, 8'h00);

        // R9 no preemption while waiting
        pulse(8'h10); wait_irq("R9 first", ok);
        pulse(8'h02);
        repeat (3) @(negedge clk);
        check("R9 still high", {31'd0, cpu_irq}, 32'd1);
        bus_read(2'd0, v); check("R9 vector unchanged", v, 8'hA4);
        bus_write(2'd3, 8'h00);
        wait_irq("R9 later delivery", ok);
        bus_read(2'd0, v); check("R9 delivered after ack", v, 8'hA1);
        bus_write(2'd3, 8'h00);

        // R2 held level does not re-trigger
        @(negedge clk); irq[0] = 1'b1;
        @(negedge clk);
        wait_irq("R2 level edge", ok);
        bus_write(2'd3, 8'h00);
        repeat (6) @(negedge clk);
        check("R2 no retrigger", {31'd0, cpu_irq}, 32'd0);
        bus_read(2'd2, v); check("R2 pending clear", v, 8'h00);
        irq[0] = 1'b0;
        @(negedge clk);

        // random phase: R7 R8 against model
        pend_m = 8'h00;
        for (int it = 0; it < 40; it++) begin
            logic [7:0] p, m, b;
            bus_write(2'd1, 8'h00); en_m = 8'h00;
            b = 8'($urandom);
            bus_write(2'd0, b); base_m = b[7:3];
            p = 8'($urandom);
            pulse(p); pend_m = pend_m | p;
            m = 8'($urandom);
            bus_write(2'd1, m); en_m = m;
            while ((pend_m & en_m) != 8'h00) begin
                int w;
                w = lowest(pend_m & en_m);
                wait_irq("R7 random irq", ok);
                if (!ok) break;
                bus_read(2'd0, v); check("R8 random vector", v, exp_vec(base_m, w));
                bus_write(2'd3, 8'h00);
                pend_m[w] = 1'b0;
            end
            check("R6 random idle", {31'd0, cpu_irq}, 32'd0);
            bus_read(2'd2, v); check("R7 random pending", v, pend_m);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule